// File: doc/BRIEF.md
# Bit-Serial Timekeeping Register Transfer Engine

This block carries a 64-bit exchange between a single bus data bit and a bank of eight 8-bit timekeeping registers. Once an upstream detector has recognised the access key, it pulses `open_i`. The engine then serves the next 64 bus cycles one bit each. A write cycle shifts the bit on `dq0_i` into a byte assembler. A read cycle places one bit of a frozen copy of the register bank on `dq0_o`. The bits run from bit 0 of register 0 up to bit 7 of register 7.

Written data reaches the registers only as complete bytes, through a one-clock parallel load strobe. A byte that was interrupted, or that mixed reads with writes, is dropped. Read data comes from a snapshot taken when the window opens, so a counter that keeps ticking cannot tear a value in the middle of a read. An active-low reset pin can abort the window without touching any register, unless a lock bit held in the day register (register 4, bit 4) is set. While the window is open, `active_o` tells the surrounding logic to keep memory accesses blocked. `done_o` marks the end of every window.

Top module: `sxf_top`

## Requirements
- R1: While `rst` is high, and in the first clock after it is released, `active_o`, `done_o`, `dq0_oe_o` and every bit of `ld_en_o` are 0.
- R2: With `active_o` low, a clock edge with `open_i` high raises `active_o`, which tells the surrounding logic to block memory accesses. While `active_o` is high, `open_i` has no effect: it neither restarts the count nor retakes the snapshot.
- R3: While the window is open, bus cycle number n (counting from 0 at the window start) with `cyc_i`=1 and `cyc_wr_i`=1 supplies bit n mod 8 of register n div 8 from `dq0_i`. In the clock after the strobe of the 8th bit of register k, `ld_en_o` has only bit k set and `ld_data_o` carries the assembled byte. This lasts one clock.
- R4: If any of a register's 8 cycles is a read (`cyc_wr_i`=0), that register is not loaded: `ld_en_o` stays 0.
- R5: A read cycle n inside the window sets `dq0_oe_o` high for one clock after its strobe, with `dq0_o` equal to bit n of the 64-bit `time_i` value (register k in bits 8k+7..8k) captured at the clock edge that opened the window. Later changes of `time_i` have no effect on it.
- R6: `dq0_oe_o` is 0 in every clock that does not follow a read strobe inside the window.
- R7: At the edge that accepts cycle 63, `active_o` falls and `done_o` rises for exactly one clock.
- R8: When `time_i[36]` is 0, a low `rst_pin_n_i` during the window ends it at the next edge: `active_o` falls and `done_o` pulses. No load is issued, and a partially assembled byte is discarded.
- R9: When `time_i[36]` is 1, `rst_pin_n_i` is ignored and the window runs to completion with all loads.
- R10: Bus strobes while `active_o` is low produce no load, no drive on `dq0_oe_o`, and no `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| open_i | input | 1 | Key recognised; opens a transfer window |
| cyc_i | input | 1 | One-clock strobe marking a bus cycle |
| cyc_wr_i | input | 1 | 1 = write cycle, 0 = read cycle, valid with `cyc_i` |
| dq0_i | input | 1 | Data bit of a write cycle |
| rst_pin_n_i | input | 1 | Active-low abort pin (already synchronised) |
| time_i | input | 64 | Live register bank, register k in bits 8k+7..8k |
| active_o | output | 1 | Window open; memory access must be blocked |
| done_o | output | 1 | One-clock pulse at window end or abort |
| dq0_o | output | 1 | Read data bit |
| dq0_oe_o | output | 1 | Drive enable for `dq0_o` |
| ld_en_o | output | 8 | One-hot register load strobe |
| ld_data_o | output | 8 | Byte to load |

## Verification
A bit counter that slips shows up at once in two ways: a read returns the snapshot bit of a neighbouring position, and the load strobe picks the wrong register or fires in the wrong clock. The bench compares every one of the 64 positions, so a slip is caught within one clock of the cycle where it happens. A stuck or wrongly cleared "all writes" flag turns into a missing or spurious load at the eighth bit of the byte. A wrong abort decision shows in the same clock as a change on `active_o` and `done_o`, or as a load that should not have happened.

// File: rtl/sxf_pkg.sv
package sxf_pkg;
  typedef enum logic {
    CYC_READ  = 1'b0,
    CYC_WRITE = 1'b1
  } cyc_kind_e;
endpackage

// File: rtl/sxf_ctrl.sv
module sxf_ctrl #(
  parameter int TOTAL = 64,
  parameter int CW    = $clog2(TOTAL)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          open_i,
  input  logic          cyc_i,
  input  logic          pin_n_i,
  input  logic          lock_i,
  output logic          active_o,
  output logic          start_o,
  output logic          step_o,
  output logic [CW-1:0] idx_o,
  output logic          done_o
);
  localparam logic [CW-1:0] LAST = CW'(TOTAL - 1);

  logic abort;

  assign abort   = active_o && !lock_i && !pin_n_i;
  assign step_o  = active_o && cyc_i && !abort;
  assign start_o = !active_o && open_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_o <= 1'b0;
      idx_o    <= '0;
      done_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_o) begin
        active_o <= 1'b1;
        idx_o    <= '0;
      end else if (abort) begin
        active_o <= 1'b0;
        done_o   <= 1'b1;
      end else if (step_o) begin
        idx_o <= idx_o + 1'b1;
        if (idx_o == LAST) begin
          active_o <= 1'b0;
          done_o   <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sxf_wpath.sv
module sxf_wpath
  import sxf_pkg::*;
#(
  parameter int REGS = 8,
  parameter int BITS = 8,
  parameter int CW   = $clog2(REGS * BITS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            step_i,
  input  logic            wr_i,
  input  logic            din_i,
  input  logic [CW-1:0]   idx_i,
  output logic [REGS-1:0] ld_en_o,
  output logic [BITS-1:0] ld_data_o
);
  localparam int BW = $clog2(BITS);
  localparam int RW = CW - BW;

  logic [BITS-1:0] sh;
  logic            all_wr;
  logic            wr_ok;
  logic [BW-1:0]   bitpos;
  logic [RW-1:0]   regsel;
  logic [BITS-1:0] full;
  logic            is_wr;

  assign bitpos = idx_i[BW-1:0];
  assign regsel = idx_i[CW-1:BW];
  assign is_wr  = (cyc_kind_e'(wr_i) == CYC_WRITE);
  assign wr_ok  = (bitpos == '0) ? is_wr : (all_wr && is_wr);

  always_comb begin
    full         = sh;
    full[BITS-1] = din_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh        <= '0;
      all_wr    <= 1'b0;
      ld_en_o   <= '0;
      ld_data_o <= '0;
    end else begin
      ld_en_o <= '0;
      if (step_i) begin
        all_wr     <= wr_ok;
        sh[bitpos] <= din_i;
        if (bitpos == BW'(BITS - 1) && wr_ok) begin
          ld_en_o   <= REGS'(1) << regsel;
          ld_data_o <= full;
        end
      end
    end
  end
endmodule

// File: rtl/sxf_rpath.sv
module sxf_rpath
  import sxf_pkg::*;
#(
  parameter int TOTAL = 64,
  parameter int CW    = $clog2(TOTAL)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [TOTAL-1:0] time_i,
  input  logic             step_i,
  input  logic             wr_i,
  input  logic [CW-1:0]    idx_i,
  output logic             dout_o,
  output logic             oe_o
);
  logic [TOTAL-1:0] snap;

  always_ff @(posedge clk) begin
    if (start_i) snap <= time_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dout_o <= 1'b0;
      oe_o   <= 1'b0;
    end else begin
      oe_o <= 1'b0;
      if (step_i && cyc_kind_e'(wr_i) == CYC_READ) begin
        dout_o <= snap[idx_i];
        oe_o   <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/sxf_top.sv
module sxf_top #(
  parameter int REGS     = 8,
  parameter int BITS     = 8,
  parameter int LOCK_REG = 4,
  parameter int LOCK_BIT = 4,
  localparam int TOTAL   = REGS * BITS,
  localparam int CW      = $clog2(TOTAL),
  localparam int LOCK_IX = LOCK_REG * BITS + LOCK_BIT
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             open_i,
  input  logic             cyc_i,
  input  logic             cyc_wr_i,
  input  logic             dq0_i,
  input  logic             rst_pin_n_i,
  input  logic [TOTAL-1:0] time_i,
  output logic             active_o,
  output logic             done_o,
  output logic             dq0_o,
  output logic             dq0_oe_o,
  output logic [REGS-1:0]  ld_en_o,
  output logic [BITS-1:0]  ld_data_o
);
  logic          start;
  logic          step;
  logic [CW-1:0] idx;

  sxf_ctrl #(.TOTAL(TOTAL), .CW(CW)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .open_i   (open_i),
    .cyc_i    (cyc_i),
    .pin_n_i  (rst_pin_n_i),
    .lock_i   (time_i[LOCK_IX]),
    .active_o (active_o),
    .start_o  (start),
    .step_o   (step),
    .idx_o    (idx),
    .done_o   (done_o)
  );

  sxf_wpath #(.REGS(REGS), .BITS(BITS), .CW(CW)) u_wpath (
    .clk       (clk),
    .rst       (rst),
    .step_i    (step),
    .wr_i      (cyc_wr_i),
    .din_i     (dq0_i),
    .idx_i     (idx),
    .ld_en_o   (ld_en_o),
    .ld_data_o (ld_data_o)
  );

  sxf_rpath #(.TOTAL(TOTAL), .CW(CW)) u_rpath (
    .clk     (clk),
    .rst     (rst),
    .start_i (start),
    .time_i  (time_i),
    .step_i  (step),
    .wr_i    (cyc_wr_i),
    .idx_i   (idx),
    .dout_o  (dq0_o),
    .oe_o    (dq0_oe_o)
  );
endmodule

// File: rtl/sxf_chk.sv
module sxf_chk #(
  parameter int REGS    = 8,
  parameter int TOTAL   = 64,
  parameter int LOCK_IX = 36
) (
  input logic             clk,
  input logic             rst,
  input logic             rst_pin_n_i,
  input logic [TOTAL-1:0] time_i,
  input logic             active_o,
  input logic             done_o,
  input logic             dq0_oe_o,
  input logic [REGS-1:0]  ld_en_o
);
  // R3
  ld_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ld_en_o));

  // R10
  ld_in_window_chk: assert property (@(posedge clk) disable iff (rst)
    (ld_en_o != '0) |-> $past(active_o));

  // R6
  oe_in_window_chk: assert property (@(posedge clk) disable iff (rst)
    dq0_oe_o |-> $past(active_o));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R7
  done_on_close_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(active_o) |-> done_o);

  // R8
  abort_clean_chk: assert property (@(posedge clk) disable iff (rst)
    (active_o && !rst_pin_n_i && !time_i[LOCK_IX]) |=> (!active_o && done_o && ld_en_o == '0));
endmodule

bind sxf_top sxf_chk #(.REGS(REGS), .TOTAL(TOTAL), .LOCK_IX(LOCK_IX)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .rst_pin_n_i (rst_pin_n_i),
  .time_i      (time_i),
  .active_o    (active_o),
  .done_o      (done_o),
  .dq0_oe_o    (dq0_oe_o),
  .ld_en_o     (ld_en_o)
);

// File: tb/sxf_top_bench.sv
`timescale 1ns/1ps
module sxf_top_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        open_i = 1'b0, cyc_i = 1'b0, cyc_wr_i = 1'b0, dq0_i = 1'b0;
  logic        rst_pin_n_i = 1'b1;
  logic [63:0] time_i = '0;
  logic        active_o, done_o, dq0_o, dq0_oe_o;
  logic [7:0]  ld_en_o, ld_data_o;

  int checks = 0;
  int fails  = 0;
  bit ended  = 0;

  always #5 clk = ~clk;

  sxf_top u_sxf_top (
    .clk(clk), .rst(rst), .open_i(open_i), .cyc_i(cyc_i), .cyc_wr_i(cyc_wr_i),
    .dq0_i(dq0_i), .rst_pin_n_i(rst_pin_n_i), .time_i(time_i),
    .active_o(active_o), .done_o(done_o), .dq0_o(dq0_o), .dq0_oe_o(dq0_oe_o),
    .ld_en_o(ld_en_o), .ld_data_o(ld_data_o)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] wbyte(input int k);
    return 8'h3C ^ 8'(k * 37);
  endfunction

  // called at a falling edge; returns at the next falling edge with outputs sampled
  task automatic bus(input logic wr, input logic d);
    cyc_i = 1'b1; cyc_wr_i = wr; dq0_i = d;
    @(negedge clk);
    cyc_i = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic open_win(input logic [63:0] t);
    time_i = t; open_i = 1'b1;
    @(negedge clk);
    open_i = 1'b0;
    chk(active_o === 1'b1, "R2 window opens", active_o, 1);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk({active_o, done_o, dq0_oe_o, ld_en_o} === '0, "R1 state in reset", {active_o, done_o, dq0_oe_o, ld_en_o}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk({active_o, done_o, dq0_oe_o, ld_en_o} === '0, "R1 state after reset", {active_o, done_o, dq0_oe_o, ld_en_o}, 0);
  endtask

  task automatic t_write_all(input logic [63:0] t, input logic pin);
    open_win(t);
    rst_pin_n_i = pin;
    for (int k = 0; k < 8; k++) begin
      for (int j = 0; j < 8; j++) begin
        bus(1'b1, wbyte(k)[j]);
        if (j == 7) begin
          chk(ld_en_o === 8'(1 << k), "R3 load strobe", ld_en_o, 64'(1 << k));
          chk(ld_data_o === wbyte(k), "R3 load byte", ld_data_o, wbyte(k));
        end else begin
          chk(ld_en_o === 8'h00, "R3 no load mid byte", ld_en_o, 0);
        end
        if (k == 7 && j == 7) begin
          chk(active_o === 1'b0 && done_o === 1'b1, "R7 close after 64", {active_o, done_o}, 1);
        end else if (pin == 1'b0) begin
          chk(active_o === 1'b1, "R9 pin ignored while locked", active_o, 1);
        end
      end
    end
    idle();
    chk(done_o === 1'b0, "R7 done lasts one clock", done_o, 0);
    rst_pin_n_i = 1'b1;
  endtask

  task automatic t_read_all();
    logic [63:0] t = 64'hF0E1_D2C3_B4A5_9687;
    open_win(t);
    time_i = ~t;
    open_i = 1'b1;
    @(negedge clk);
    open_i = 1'b0;
    chk(dq0_oe_o === 1'b0, "R6 no drive without read", dq0_oe_o, 0);
    for (int n = 0; n < 64; n++) begin
      bus(1'b0, 1'b0);
      chk(dq0_oe_o === 1'b1 && dq0_o === t[n], "R5 snapshot bit", {dq0_oe_o, dq0_o}, {1'b1, t[n]});
      if (n == 63)
        chk(done_o === 1'b1 && active_o === 1'b0, "R7 close after 64 reads", {active_o, done_o}, 1);
      else
        chk(active_o === 1'b1, "R2 open_i ignored mid window", active_o, 1);
    end
    idle();
    chk(dq0_oe_o === 1'b0, "R6 drive released", dq0_oe_o, 0);
  endtask

  task automatic t_mixed_abort();
    logic [63:0] t = 64'h0123_4567_89AB_CDEF & ~(64'd1 << 36);
    open_win(t);
    for (int j = 0; j < 8; j++) bus(1'b1, wbyte(0)[j]);
    chk(ld_en_o === 8'h01, "R3 byte 0 loads", ld_en_o, 1);
    for (int j = 0; j < 8; j++) begin
      if (j == 3) begin
        bus(1'b0, 1'b0);
        chk(dq0_oe_o === 1'b1 && dq0_o === t[11], "R5 read inside mixed byte", dq0_o, t[11]);
      end else begin
        bus(1'b1, 1'b1);
        chk(dq0_oe_o === 1'b0, "R6 no drive on write", dq0_oe_o, 0);
      end
    end
    chk(ld_en_o === 8'h00, "R4 mixed byte not loaded", ld_en_o, 0);
    for (int j = 0; j < 3; j++) bus(1'b1, 1'b1);
    rst_pin_n_i = 1'b0;
    idle();
    chk(active_o === 1'b0 && done_o === 1'b1, "R8 abort closes window", {active_o, done_o}, 1);
    chk(ld_en_o === 8'h00, "R8 abort loads nothing", ld_en_o, 0);
    rst_pin_n_i = 1'b1;
    idle();
    chk(done_o === 1'b0, "R8 abort done one clock", done_o, 0);
    for (int j = 0; j < 8; j++) begin
      bus(1'b1, 1'b1);
      chk({ld_en_o, dq0_oe_o, done_o, active_o} === '0, "R10 idle write ignored", {ld_en_o, dq0_oe_o, done_o, active_o}, 0);
    end
    bus(1'b0, 1'b0);
    chk({dq0_oe_o, active_o} === '0, "R10 idle read ignored", {dq0_oe_o, active_o}, 0);
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_write_all(64'h0, 1'b1);
    t_read_all();
    t_mixed_abort();
    t_write_all(64'd1 << 36, 1'b0);
    repeat (2) idle();
    finish_run();
  end
endmodule